// File: doc/BRIEF.md
# General-Purpose Pin Function Multiplexer

This block decides what a single general-purpose pad carries. A 3-bit select code picks one of several internal sources for the pad's output: a temperature-healthy flag, an auto-mute-active flag, a ratio-divided copy of the PLL clock, the PLL lock flag, or a fixed 0 or 1. The two lowest codes leave the pad as an input with its driver turned off. A polarity bit inverts whatever value is driven.

The PLL clock divider runs all the time on the PLL clock. A 2-bit ratio picks division by 1, 2, 3 or 4. A new ratio is adopted only when the current output period completes, so the clock reaching the pad never carries a shortened pulse. When the serial-interface mode input selects three-wire operation, the pad is always an input that carries the interface chip-select, whatever the select code says. The chip-select path is brought out separately.

The register fields arrive as plain inputs. The register file, its reset values and the pad cell are outside this block.

Top module: `gpio_pin_mux`

## Requirements
- R1: Select codes 000 (input) and 001 (reserved) hold `pad_oe` low and `pad_out` low.
- R2: Codes 010, 011 and 101 raise `pad_oe` and drive `temp_ok`, `amute_act` and `pll_lock` respectively, with no clock delay.
- R3: Code 110 drives a constant 0 and code 111 drives a constant 1, both with `pad_oe` high.
- R4: With `pin_pol` at 1, every driven code puts the inverse of its source on `pad_out`. With `pin_pol` at 0 the source passes through unchanged.
- R5: While `three_wire` is 1, `pad_oe` and `pad_out` are low for every select code, and `csb_in_n` equals `pad_in`. While `three_wire` is 0, `csb_in_n` is 1.
- R6: Code 100 raises `pad_oe` and drives the divided PLL clock. Ratio 00 passes the PLL clock through unchanged, high while `clk` is high.
- R7: Ratios 01 and 11 give an output period of exactly 2 and 4 PLL clocks. The output is high for half of each period and changes only on rising edges of `clk`.
- R8: Ratio 10 gives an output period of exactly 3 PLL clocks: high for 2 clocks, then low for 1.
- R9: A ratio change takes effect only after the current output period completes. The new period then starts with its high phase.
- R10: After reset release the divider starts at the beginning of a period with ratio 00 in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL clock; clocks the divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_sel | input | 3 | Pad source select code |
| pin_pol | input | 1 | Invert the driven pad value when 1 |
| clk_ratio | input | 2 | PLL clock division ratio (N-1) |
| three_wire | input | 1 | Three-wire interface mode; forces the pad to be the chip-select input |
| temp_ok | input | 1 | Temperature-healthy status flag |
| amute_act | input | 1 | Auto-mute-active status flag |
| pll_lock | input | 1 | PLL lock status flag |
| pad_in | input | 1 | Value received from the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad output driver enable |
| csb_in_n | output | 1 | Chip-select input path, active low, idle high |

## Verification
The select path is swept over every combination of the eight codes, both polarities, both interface modes and all eight patterns of the three status flags, with `pad_in` toggled alongside. This separates each source from its neighbours, shows that inversion applies only to driven codes, and shows that three-wire mode overrides every code. The divider is observed at both clock phases for each ratio. Each captured sequence is checked for its period, its count of high cycles per period and for equal values in the two halves of each clock cycle; this tells pass-through apart from division and divide-by-3 apart from divide-by-4. A ratio change issued just after a rising output edge tells an immediate switch apart from one deferred to the end of the period.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  localparam int SEL_W   = 3;
  localparam int RATIO_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_INPUT  = 3'd0,
    SEL_RSVD   = 3'd1,
    SEL_TEMP   = 3'd2,
    SEL_AMUTE  = 3'd3,
    SEL_PLLCLK = 3'd4,
    SEL_LOCK   = 3'd5,
    SEL_ZERO   = 3'd6,
    SEL_ONE    = 3'd7
  } pin_sel_e;

endpackage

// File: rtl/pll_ratio_div.sv
module pll_ratio_div #(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               clk_div_o
);

  localparam int HW_W = RATIO_W + 1;

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [RATIO_W-1:0] cur_q, cur_d;
  logic               div_q, div_d;
  logic               wrap;
  logic [HW_W-1:0]    hi_len_d;

  // period end: counter reached the active ratio (period = cur + 1)
  assign wrap = (cnt_q == cur_q);

  always_comb begin
    if (wrap) begin
      cnt_d = '0;
      cur_d = ratio_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
      cur_d = cur_q;
    end
    // high phase length = ceil(period/2) = (cur + 2) / 2
    hi_len_d = HW_W'((HW_W'(cur_d) + HW_W'(2)) >> 1);
    div_d    = (HW_W'(cnt_d) < hi_len_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cur_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cur_q <= cur_d;
      div_q <= div_d;
    end
  end

  // ratio 0 passes the PLL clock straight through; switch happens only at a wrap
  assign clk_div_o = (cur_q == '0) ? clk : div_q;

  // R9
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(cur_q));

  // R9
  wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cur_q);

  // R8
  period_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && cur_q != '0 && $past(rst_n)) |-> div_q);

endmodule

// File: rtl/pin_src_sel.sv
module pin_src_sel
  import gpio_mux_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic             temp_ok_i,
  input  logic             amute_i,
  input  logic             clk_div_i,
  input  logic             lock_i,
  output logic             src_o,
  output logic             drive_o
);

  pin_sel_e sel;
  assign sel = pin_sel_e'(sel_i);

  always_comb begin
    src_o   = 1'b0;
    drive_o = 1'b1;
    unique case (sel)
      SEL_INPUT,
      SEL_RSVD:   drive_o = 1'b0;
      SEL_TEMP:   src_o   = temp_ok_i;
      SEL_AMUTE:  src_o   = amute_i;
      SEL_PLLCLK: src_o   = clk_div_i;
      SEL_LOCK:   src_o   = lock_i;
      SEL_ZERO:   src_o   = 1'b0;
      SEL_ONE:    src_o   = 1'b1;
      default:    drive_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_mux_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   pin_sel,
  input  logic               pin_pol,
  input  logic [RATIO_W-1:0] clk_ratio,
  input  logic               three_wire,
  input  logic               temp_ok,
  input  logic               amute_act,
  input  logic               pll_lock,
  input  logic               pad_in,
  output logic               pad_out,
  output logic               pad_oe,
  output logic               csb_in_n
);

  logic clk_div;
  logic src;
  logic drive;

  pll_ratio_div #(.RATIO_W(RATIO_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_i   (clk_ratio),
    .clk_div_o (clk_div)
  );

  pin_src_sel u_sel (
    .sel_i     (pin_sel),
    .temp_ok_i (temp_ok),
    .amute_i   (amute_act),
    .clk_div_i (clk_div),
    .lock_i    (pll_lock),
    .src_o     (src),
    .drive_o   (drive)
  );

  // three-wire mode overrides the select code
  assign pad_oe   = drive & ~three_wire;
  assign pad_out  = pad_oe & (src ^ pin_pol);
  assign csb_in_n = three_wire ? pad_in : 1'b1;

  // R5
  three_wire_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    three_wire |-> (!pad_oe && !pad_out));

  // R1
  input_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel == SEL_INPUT || pin_sel == SEL_RSVD) |-> !pad_oe);

  // R2
  temp_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel == SEL_TEMP && !three_wire) |-> (pad_oe && pad_out == (temp_ok ^ pin_pol)));

  // R3
  const_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel == SEL_ONE && !three_wire) |-> (pad_out == !pin_pol));

endmodule

// File: tb/gpio_pin_mux_test.sv
module gpio_pin_mux_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] pin_sel;
  logic       pin_pol;
  logic [1:0] clk_ratio;
  logic       three_wire;
  logic       temp_ok, amute_act, pll_lock, pad_in;
  logic       pad_out, pad_oe, csb_in_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  gpio_pin_mux uut (
    .clk(clk), .rst_n(rst_n), .pin_sel(pin_sel), .pin_pol(pin_pol),
    .clk_ratio(clk_ratio), .three_wire(three_wire), .temp_ok(temp_ok),
    .amute_act(amute_act), .pll_lock(pll_lock), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .csb_in_n(csb_in_n)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  // capture one sequence at both clock phases and check its shape
  task automatic measure(input int ratio, input string req);
    bit h[16];
    bit l[16];
    int n, highs, rises;
    bit same;
    n = ratio + 1;
    pin_sel = 3'd4; pin_pol = 0; three_wire = 0;
    clk_ratio = 2'(ratio);
    repeat (10) @(posedge clk);
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #5 h[i] = pad_out;
      #10 l[i] = pad_out;
    end
    check(req, "divider oe", int'(pad_oe), 1);
    if (n == 1) begin
      highs = 0; rises = 0;
      for (int i = 0; i < 16; i++) begin
        highs += h[i];
        rises += l[i];
      end
      check(req, "pass-through high phase count", highs, 16);
      check(req, "pass-through low phase count", rises, 0);
    end else begin
      same = 1;
      for (int i = 0; i < 16; i++) if (h[i] != l[i]) same = 0;
      check(req, "stable within clock cycle", int'(same), 1);
      same = 1;
      for (int i = 0; i + n < 16; i++) if (h[i] != h[i+n]) same = 0;
      check(req, "period repeats", int'(same), 1);
      highs = 0; rises = 0;
      for (int i = 0; i < n; i++) begin
        highs += h[i];
        if (h[(i+1) % n] && !h[i]) rises++;
      end
      check(req, "high cycles per period", highs, (n + 1) / 2);
      check(req, "rising edges per period", rises, 1);
    end
  endtask

  initial begin
    bit prev;
    int src, exp_oe, exp_out;
    string tag;
    bit seq[6];
    rst_n = 0; pin_sel = 0; pin_pol = 0; clk_ratio = 0; three_wire = 0;
    temp_ok = 0; amute_act = 0; pll_lock = 0; pad_in = 0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    @(posedge clk); #5;
    check("R1", "oe after reset", int'(pad_oe), 0);
    check("R1", "out after reset", int'(pad_out), 0);
    check("R5", "csb idle after reset", int'(csb_in_n), 1);

    // R10: ratio 00 in effect straight after reset
    pin_sel = 3'd4;
    #1 check("R10", "clock high phase after reset", int'(pad_out), 1);
    #8 check("R10", "clock low phase after reset", int'(pad_out), 0);

    // exhaustive select sweep
    @(posedge clk); #5;
    for (int tw = 0; tw < 2; tw++)
      for (int pol = 0; pol < 2; pol++)
        for (int s = 0; s < 8; s++)
          for (int f = 0; f < 8; f++) begin
            three_wire = tw[0]; pin_pol = pol[0]; pin_sel = 3'(s);
            temp_ok = f[0]; amute_act = f[1]; pll_lock = f[2]; pad_in = ~f[0];
            #1;
            case (s)
              2: src = f & 1;
              3: src = (f >> 1) & 1;
              5: src = (f >> 2) & 1;
              7: src = 1;
              default: src = 0;
            endcase
            exp_oe  = (tw == 0 && s >= 2) ? 1 : 0;
            exp_out = exp_oe ? (src ^ pol) : 0;
            if (tw == 1) tag = "R5";
            else if (s < 2) tag = "R1";
            else if (pol == 1 && s != 4) tag = "R4";
            else if (s == 6 || s == 7) tag = "R3";
            else if (s == 4) tag = "R6";
            else tag = "R2";
            check(tag, $sformatf("oe sel=%0d", s), int'(pad_oe), exp_oe);
            if (s != 4 || tw == 1)
              check(tag, $sformatf("out sel=%0d pol=%0d f=%0d", s, pol, f), int'(pad_out), exp_out);
            check("R5", "chip-select path", int'(csb_in_n), tw ? int'(~f[0] & 1) : 1);
          end

    measure(0, "R6");
    measure(1, "R7");
    measure(3, "R7");
    measure(2, "R8");

    // R4 on the divided clock
    pin_pol = 1; clk_ratio = 2'd1;
    repeat (6) @(posedge clk);
    @(posedge clk); #5 prev = pad_out;
    @(posedge clk); #5;
    check("R4", "inverted divided clock alternates", int'(pad_out != prev), 1);
    pin_pol = 0;

    // R9: deferred ratio change from /4 to /2
    clk_ratio = 2'd3;
    repeat (10) @(posedge clk);
    @(posedge clk); #5 prev = pad_out;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #5;
      if (!prev && pad_out) break;
      prev = pad_out;
    end
    #10 clk_ratio = 2'd1;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #5 seq[i] = pad_out;
    end
    check("R9", "old period finishes k+1", int'(seq[0]), 1);
    check("R9", "old period finishes k+2", int'(seq[1]), 0);
    check("R9", "old period finishes k+3", int'(seq[2]), 0);
    check("R9", "new period starts high", int'(seq[3]), 1);
    check("R9", "new period low", int'(seq[4]), 0);
    check("R9", "new period repeats", int'(seq[5]), 1);

    report();
  end

endmodule